// File: doc/BRIEF.md
# Unit-to-Register Hazard Matrix

This block keeps the register hazard state for a small out-of-order core that has no associative lookups. Every function unit owns a row of one-hot and unary bit vectors, one bit per architectural register. One vector marks the registers the unit still has to read. One marks the register it will write, and that bit doubles as the unit's rename tag for its destination. The third marks the sources that were waiting on an older writer when the instruction issued. The rows are ORed into chip-wide read-pending and write-pending vectors. From these the block works out which units may read their operands and which may write their result.

Two lowest-index pickers turn the request vectors into at most one read grant and one write grant per cycle. The selected unit's row then appears directly as the register-file read enables or write enables. The read requests pass through a register, which breaks the combinational path from grant back to request. As a result, a unit moves from issue to read to write over at least three clock edges. An incoming instruction is refused with a stall when its destination already has a write pending.

Top module: `regdep_matrix`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every row, so the cycle after reset shows rd_pending, wr_pending, go_read and go_write all zero.
- R2: An accepted issue (issue_valid high, issue_stall low) loads the row of unit issue_unit at that edge. Bit issue_dst of wr_pending is set and, for each enabled source, bit issue_src_a / issue_src_b of rd_pending is set, both visible in the next cycle.
- R3: rd_pending and wr_pending are the bitwise OR of all units' read rows and write rows respectively.
- R4: issue_stall is high in the same cycle when issue_valid is high and bit issue_dst of wr_pending is already set; a stalled issue changes no row.
- R5: Read requests are registered, so go_read for a unit is low in the cycle right after its issue edge and can be high at the earliest one cycle later.
- R6: A source register that had a write pending from another unit at issue time (and not being written in that cycle) holds the reader back from go_read until that write's go_write has been given and the registered request has caught up.
- R7: While go_read selects a unit, rf_rd_en equals that unit's source bits; those bits are gone from its row at the next edge.
- R8: go_write selects a unit only when its reads are done and no other unit still has an unwaited read pending on its destination (write-after-read). While selected, rf_wr_en is the one-hot destination, which leaves wr_pending at the next edge.
- R9: go_read and go_write are each zero or one-hot (bit i = unit i); among several requesting units the lowest-numbered one is granted.
- R10: A unit issued with neither source enabled can receive go_write in the cycle right after its issue edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is offered to an idle unit |
| issue_unit | input | UNIT_W | Index of the receiving unit |
| issue_dst | input | REG_W | Destination register number |
| issue_src_a | input | REG_W | First source register number |
| issue_src_a_en | input | 1 | First source is used |
| issue_src_b | input | REG_W | Second source register number |
| issue_src_b_en | input | 1 | Second source is used |
| issue_stall | output | 1 | Issue refused: destination already has a write pending |
| go_read | output | NUM_UNITS | One-hot read grant per unit |
| go_write | output | NUM_UNITS | One-hot write grant per unit |
| rf_rd_en | output | NUM_REGS | Register-file read enables of the granted reader |
| rf_wr_en | output | NUM_REGS | Register-file write enable of the granted writer |
| rd_pending | output | NUM_REGS | Global read-pending vector |
| wr_pending | output | NUM_REGS | Global write-pending vector |

## Verification
The hardest case to reach is a chain with several links: a reader issued after a writer of its source, itself followed by a later writer of a register that an older reader still holds. In that chain the wait bits and the write-after-read blocking must both be correct, or the units deadlock or read too early. Directed sequences build this chain, along with three units becoming writable in the same cycle. Random traffic uses only eight of the registers, so that such overlaps recur, and every cycle is compared against a bench model of the rows.

// File: rtl/regdep_pkg.sv
package regdep_pkg;
    localparam int DEF_UNITS = 4;
    localparam int DEF_REGS  = 16;
endpackage

// File: rtl/regdep_picker.sv
module regdep_picker #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/regdep_row.sv
module regdep_row #(
    parameter int NREG = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [NREG-1:0] dst_oh,
    input  logic [NREG-1:0] src_mask,
    input  logic [NREG-1:0] busy_wr,
    input  logic            go_rd,
    input  logic            go_wr,
    input  logic [NREG-1:0] wr_clear,
    output logic [NREG-1:0] rd_row,
    output logic [NREG-1:0] wr_row,
    output logic [NREG-1:0] wait_row
);
    typedef struct packed {
        logic [NREG-1:0] rd;
        logic [NREG-1:0] wr;
        logic [NREG-1:0] wt;
    } row_t;

    row_t row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (load) begin
            row_d.rd = src_mask;
            row_d.wr = dst_oh;
            row_d.wt = src_mask & busy_wr;
        end else begin
            if (go_rd) row_d.rd = '0;
            if (go_wr) row_d.wr = '0;
            row_d.wt = row_q.wt & ~wr_clear;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) row_q <= '0;
        else     row_q <= row_d;
    end

    assign rd_row   = row_q.rd;
    assign wr_row   = row_q.wr;
    assign wait_row = row_q.wt;

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (go_rd && !load) |=> (row_q.rd == '0));

    // R8
    wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (go_wr && !load) |=> (row_q.wr == '0));

    // R2
    tag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> $onehot(row_q.wr));
endmodule

// File: rtl/regdep_matrix.sv
module regdep_matrix
    import regdep_pkg::*;
#(
    parameter int NUM_UNITS = DEF_UNITS,
    parameter int NUM_REGS  = DEF_REGS,
    localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_valid,
    input  logic [UNIT_W-1:0]    issue_unit,
    input  logic [REG_W-1:0]     issue_dst,
    input  logic [REG_W-1:0]     issue_src_a,
    input  logic                 issue_src_a_en,
    input  logic [REG_W-1:0]     issue_src_b,
    input  logic                 issue_src_b_en,
    output logic                 issue_stall,
    output logic [NUM_UNITS-1:0] go_read,
    output logic [NUM_UNITS-1:0] go_write,
    output logic [NUM_REGS-1:0]  rf_rd_en,
    output logic [NUM_REGS-1:0]  rf_wr_en,
    output logic [NUM_REGS-1:0]  rd_pending,
    output logic [NUM_REGS-1:0]  wr_pending
);
    typedef struct packed {
        logic [NUM_UNITS-1:0] readable;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_REGS-1:0]  rd_row   [NUM_UNITS];
    logic [NUM_REGS-1:0]  wr_row   [NUM_UNITS];
    logic [NUM_REGS-1:0]  wait_row [NUM_UNITS];
    logic [NUM_REGS-1:0]  blk_row  [NUM_UNITS];
    logic [NUM_UNITS-1:0] wr_col   [NUM_REGS];
    logic [NUM_UNITS-1:0] load_vec, rd_any, writable, rd_req;
    logic [NUM_REGS-1:0]  dst_oh, src_mask, busy_wr;

    // issue decode
    always_comb begin
        dst_oh   = NUM_REGS'(1) << issue_dst;
        src_mask = '0;
        if (issue_src_a_en) src_mask = src_mask | (NUM_REGS'(1) << issue_src_a);
        if (issue_src_b_en) src_mask = src_mask | (NUM_REGS'(1) << issue_src_b);
        issue_stall = issue_valid && wr_pending[issue_dst];
        for (int f = 0; f < NUM_UNITS; f++)
            load_vec[f] = issue_valid && !issue_stall && (issue_unit == UNIT_W'(f));
    end

    // global OR and hazard derivation
    always_comb begin
        rd_pending = '0;
        wr_pending = '0;
        for (int f = 0; f < NUM_UNITS; f++) begin
            rd_pending = rd_pending | rd_row[f];
            wr_pending = wr_pending | wr_row[f];
            blk_row[f] = rd_row[f] & ~wait_row[f];
            rd_any[f]  = |rd_row[f];
        end
        for (int r = 0; r < NUM_REGS; r++)
            for (int f = 0; f < NUM_UNITS; f++)
                wr_col[r][f] = wr_row[f][r];
        for (int f = 0; f < NUM_UNITS; f++) begin
            logic [NUM_REGS-1:0] others;
            others = '0;
            for (int g = 0; g < NUM_UNITS; g++)
                if (g != f) others = others | blk_row[g];
            writable[f] = (|wr_row[f]) && !rd_any[f] && !(|(wr_row[f] & others));
        end
        rd_req = ctl_q.readable & rd_any;
    end

    regdep_picker #(.N(NUM_UNITS)) i_rd_pick (.req(rd_req),   .grant(go_read));
    regdep_picker #(.N(NUM_UNITS)) i_wr_pick (.req(writable), .grant(go_write));

    // grants drive the register-file enables
    always_comb begin
        rf_rd_en = '0;
        rf_wr_en = '0;
        for (int f = 0; f < NUM_UNITS; f++) begin
            if (go_read[f])  rf_rd_en = rf_rd_en | rd_row[f];
            if (go_write[f]) rf_wr_en = rf_wr_en | wr_row[f];
        end
        busy_wr = wr_pending & ~rf_wr_en;
    end

    // registered read requests
    always_comb begin
        ctl_d = ctl_q;
        for (int f = 0; f < NUM_UNITS; f++)
            ctl_d.readable[f] = rd_any[f] && (wait_row[f] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    for (genvar f = 0; f < NUM_UNITS; f++) begin : g_row
        regdep_row #(.NREG(NUM_REGS)) i_row (
            .clk      (clk),
            .rst      (rst),
            .load     (load_vec[f]),
            .dst_oh   (dst_oh),
            .src_mask (src_mask),
            .busy_wr  (busy_wr),
            .go_rd    (go_read[f]),
            .go_wr    (go_write[f]),
            .wr_clear (rf_wr_en),
            .rd_row   (rd_row[f]),
            .wr_row   (wr_row[f]),
            .wait_row (wait_row[f])
        );

        // R5
        read_delay_chk: assert property (@(posedge clk) disable iff (rst)
            go_read[f] |-> $past(rd_any[f] && (wait_row[f] == '0)));
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_col
        // R4
        single_writer_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(wr_col[r]));
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_pending == '0 && wr_pending == '0 && go_read == '0));

    // R4
    stall_noload_chk: assert property (@(posedge clk) disable iff (rst)
        issue_stall |=> ((wr_pending & ~$past(wr_pending)) == '0));

    // R8
    wr_en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rf_wr_en));
endmodule

// File: tb/test_regdep_matrix.sv
module test_regdep_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 4;
    localparam int NR = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iv = 1'b0, ae = 1'b0, be = 1'b0;
    logic [1:0] iu = '0;
    logic [3:0] idst = '0, ia = '0, ib = '0;
    logic stall;
    logic [NU-1:0] gr, gw;
    logic [NR-1:0] rfrd, rfwr, rdp, wrp;

    int checks = 0;
    int errs = 0;

    logic [NR-1:0] m_rd [NU];
    logic [NR-1:0] m_wr [NU];
    logic [NR-1:0] m_wt [NU];
    logic [NU-1:0] m_readable;
    logic [NU-1:0] s_gr, s_gw;
    logic          s_stall;
    logic [NR-1:0] s_rfrd;

    always #(CLK_PERIOD/2) clk = ~clk;

    regdep_matrix i_regdep_matrix (
        .clk(clk), .rst(rst), .issue_valid(iv), .issue_unit(iu), .issue_dst(idst),
        .issue_src_a(ia), .issue_src_a_en(ae), .issue_src_b(ib), .issue_src_b_en(be),
        .issue_stall(stall), .go_read(gr), .go_write(gw), .rf_rd_en(rfrd),
        .rf_wr_en(rfwr), .rd_pending(rdp), .wr_pending(wrp)
    );

    task automatic chk(input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NU-1:0] lowest(input logic [NU-1:0] r);
        logic [NU-1:0] g;
        g = '0;
        for (int i = 0; i < NU; i++)
            if (r[i] && g == '0) g[i] = 1'b1;
        return g;
    endfunction

    function automatic logic model_idle(input int u);
        return (m_rd[u] == '0) && (m_wr[u] == '0);
    endfunction

    // one cycle: drive at negedge, compare after settle, advance model at posedge
    task automatic cyc(input logic v, input int u, input int d,
                       input int a, input logic a_en, input int b, input logic b_en);
        logic [NR-1:0] e_rdp, e_wrp, e_rfrd, e_rfwr, smask, busy, oh;
        logic [NU-1:0] rdany, wrable, e_gr, e_gw, nread;
        logic e_stall;
        iv = v; iu = 2'(u); idst = 4'(d); ia = 4'(a); ae = a_en; ib = 4'(b); be = b_en;
        #1;
        e_rdp = '0; e_wrp = '0;
        for (int f = 0; f < NU; f++) begin
            e_rdp |= m_rd[f];
            e_wrp |= m_wr[f];
            rdany[f] = |m_rd[f];
        end
        e_stall = v && e_wrp[d];
        for (int f = 0; f < NU; f++) begin
            logic [NR-1:0] oth;
            oth = '0;
            for (int g = 0; g < NU; g++)
                if (g != f) oth |= m_rd[g] & ~m_wt[g];
            wrable[f] = (|m_wr[f]) && !rdany[f] && !(|(m_wr[f] & oth));
        end
        e_gr = lowest(m_readable & rdany);
        e_gw = lowest(wrable);
        e_rfrd = '0; e_rfwr = '0;
        for (int f = 0; f < NU; f++) begin
            if (e_gr[f]) e_rfrd |= m_rd[f];
            if (e_gw[f]) e_rfwr |= m_wr[f];
        end
        chk("R2 R3 rd_pending", rdp, e_rdp);
        chk("R2 R3 wr_pending", wrp, e_wrp);
        chk("R4 issue_stall", NR'(stall), NR'(e_stall));
        chk("R5 R6 R9 go_read", NR'(gr), NR'(e_gr));
        chk("R8 R9 R10 go_write", NR'(gw), NR'(e_gw));
        chk("R7 rf_rd_en", rfrd, e_rfrd);
        chk("R8 rf_wr_en", rfwr, e_rfwr);
        s_gr = gr; s_gw = gw; s_stall = stall; s_rfrd = rfrd;
        oh = NR'(1) << d;
        smask = '0;
        if (a_en) smask |= NR'(1) << a;
        if (b_en) smask |= NR'(1) << b;
        busy = e_wrp & ~e_rfwr;
        for (int f = 0; f < NU; f++) nread[f] = rdany[f] && (m_wt[f] == '0);
        @(posedge clk);
        for (int f = 0; f < NU; f++) begin
            if (v && !e_stall && u == f) begin
                m_rd[f] = smask; m_wr[f] = oh; m_wt[f] = smask & busy;
            end else begin
                if (e_gr[f]) m_rd[f] = '0;
                if (e_gw[f]) m_wr[f] = '0;
                m_wt[f] = m_wt[f] & ~e_rfwr;
            end
        end
        m_readable = nread;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int f = 0; f < NU; f++) begin m_rd[f] = '0; m_wr[f] = '0; m_wt[f] = '0; end
        m_readable = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 rd_pending", rdp, '0);
        chk("R1 wr_pending", wrp, '0);
        chk("R1 grants", NR'({gr, gw}), '0);
        @(negedge clk);

        // R10: no sources, write right after issue
        cyc(1'b1, 1, 3, 0, 1'b0, 0, 1'b0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R10 go_write next cycle", NR'(s_gw), NR'(4'b0010));
        idle(4);

        // R5 / R7: registered read request
        cyc(1'b1, 2, 4, 1, 1'b1, 0, 1'b0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R5 no go_read right after issue", NR'(s_gr), '0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R5 go_read one cycle later", NR'(s_gr), NR'(4'b0100));
        chk("R7 rf_rd_en source bit", s_rfrd, NR'(16'h0002));
        idle(4);

        // R4 / R6: stall on pending destination, reader waits for writer
        cyc(1'b1, 0, 5, 6, 1'b1, 0, 1'b0);
        cyc(1'b1, 3, 5, 0, 1'b0, 0, 1'b0);
        chk("R4 stall on pending dst", NR'(s_stall), NR'(1));
        cyc(1'b1, 1, 7, 5, 1'b1, 0, 1'b0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R8 writer granted", NR'(s_gw), NR'(4'b0001));
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R6 reader still held", NR'(s_gr), '0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R6 reader released", NR'(s_gr), NR'(4'b0010));
        idle(5);

        // R8 / R9: write-after-read block, then lowest-index priority
        cyc(1'b1, 3, 11, 10, 1'b1, 0, 1'b0);
        cyc(1'b1, 2, 10, 0, 1'b0, 0, 1'b0);
        cyc(1'b1, 0, 12, 0, 1'b0, 0, 1'b0);
        chk("R8 WaR blocks writer", NR'(s_gw), '0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R9 lowest of three", NR'(s_gw), NR'(4'b0001));
        cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        chk("R9 next lowest", NR'(s_gw), NR'(4'b0100));
        idle(6);

        // constrained random traffic on registers 0..7
        for (int n = 0; n < 3000; n++) begin
            int start, pick;
            pick = -1;
            start = int'($urandom_range(NU - 1));
            for (int k = 0; k < NU; k++)
                if (pick < 0 && model_idle((start + k) % NU)) pick = (start + k) % NU;
            if (pick >= 0 && $urandom_range(9) < 6)
                cyc(1'b1, pick, int'($urandom_range(7)), int'($urandom_range(7)),
                    1'($urandom_range(1)), int'($urandom_range(7)), 1'($urandom_range(1)));
            else
                cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
        end
        idle(20);
        chk("R8 drained wr_pending", wrp, '0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule